// File: doc/BRIEF.md
# Operand Address Generator

This block works out where an instruction operand lives, for a processor whose ALU instructions may take one operand straight from memory. Decode logic presents an addressing-mode code together with the values the mode may need: a base register value, an index register value, a signed displacement, the current program counter, the literal field of the instruction and a 2-bit operand size. One cycle later the block returns the effective address and a flag that says whether memory is touched at all. For the two self-updating pointer modes, it also returns the new pointer value and a write enable for the register file.

The mode that takes its address from memory needs one extra read. The block raises a pointer request carrying the literal address and waits for a one-cycle valid strobe with the fetched word. That word becomes the effective address. While this fetch is in progress the block reports busy and ignores new starts. The 32-bit address width and the displacement width are parameters. Displacements are sign-extended, and all address sums wrap modulo 2^32.

Top module: `ea_unit`

## Requirements
- R1: While reset is active and after it is released, `done`, `busy`, `ptr_req`, `mem_acc` and `wb_en` are 0 and `ea` and `wb_val` are zero.
- R2: Immediate mode (code 0) and register mode (code 1) give `mem_acc`=0, `ea`=0 and `wb_en`=0.
- R3: Absolute mode (code 2) gives `ea`=`lit` with `mem_acc`=1. Register-indirect mode (code 3) gives `ea`=`base_val` with `mem_acc`=1.
- R4: Index mode (code 5) gives `ea`=`base_val`+sext(`disp`). Base+index mode (code 6) gives `base_val`+`index_val`. Base+index+offset mode (code 7) gives `base_val`+`index_val`+sext(`disp`). All three have `mem_acc`=1, and the sums wrap modulo 2^AW (for example 1200+4600+30 = 5830).
- R5: PC-relative mode (code 8) gives `ea`=`pc`+sext(`disp`) with `mem_acc`=1.
- R6: The step d is 1, 2, 4 and 4 for `size` codes 0, 1, 2 and 3. Post-increment mode (code 9) gives `ea`=`base_val`, `wb_val`=`base_val`+d and `wb_en`=1.
- R7: Pre-decrement mode (code 10) gives `ea`=`wb_val`=`base_val`-d, wrapping below zero, with `wb_en`=1.
- R8: `wb_en` is 1 only for results of codes 9 and 10.
- R9: Codes 11 to 15 are reserved and give `mem_acc`=0, `ea`=0 and `wb_en`=0.
- R10: For memory-indirect mode (code 4), `ptr_req` and `busy` go high one cycle after the start, with `ptr_addr`=`lit`. Both stay high with `ptr_addr` held until `ptr_valid` is seen.
- R11: On the edge that samples `ptr_valid` while `ptr_req` is high, the block registers `done`=1, `ea`=`ptr_data`, `mem_acc`=1 and `wb_en`=0, and drops `ptr_req`.
- R12: A `start` that arrives while `busy` is high is ignored: it produces no `done` and does not change the pending result.
- R13: For every mode except code 4, `done` pulses for exactly one cycle, in the cycle after an accepted start. Results hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an address computation |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Operand size code (byte, half, word, word) |
| base_val | input | AW | Base/pointer register value |
| index_val | input | AW | Index register value |
| disp | input | DISP_W | Signed displacement |
| pc | input | AW | Current program counter |
| lit | input | AW | Literal field of the instruction |
| ptr_valid | input | 1 | Pointer word returned (one-cycle strobe) |
| ptr_data | input | AW | Fetched pointer word |
| busy | output | 1 | Indirect fetch in progress |
| ptr_req | output | 1 | Pointer fetch request |
| ptr_addr | output | AW | Address of the pointer word |
| done | output | 1 | Result valid strobe |
| ea | output | AW | Effective address |
| mem_acc | output | 1 | Operand needs a memory access |
| wb_en | output | 1 | Pointer register update enable |
| wb_val | output | AW | New pointer register value |

## Verification
Every mode except memory-indirect registers its result on the first rising edge after `start`. The bench drives `start` on a falling edge and reads `done` and the result fields on the next falling edge. It then checks, one cycle later, that `done` has dropped. For memory-indirect mode, the bench checks `ptr_req` and `ptr_addr` on the falling edge after `start` and keeps checking them during a wait of zero to three cycles. It pulses `ptr_valid` for one cycle and expects the result on the falling edge that follows. A stray `start` is injected during the wait to confirm that it is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_REG   = 4'd1,
    AM_ABS   = 4'd2,
    AM_RIND  = 4'd3,
    AM_MIND  = 4'd4,
    AM_IDX   = 4'd5,
    AM_BIDX  = 4'd6,
    AM_BIDXO = 4'd7,
    AM_PCREL = 4'd8,
    AM_PINC  = 4'd9,
    AM_PDEC  = 4'd10
  } amode_e;

  // operand size code to byte step; code 3 is treated as a word
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    unique case (sz)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  a,
  output logic [OUT_W-1:0] y
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign y = {{PAD_W{a[IN_W-1]}}, a};
    end else begin : g_same
      assign y = a[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_comb.sv
module ea_comb
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] disp_x,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] lit,
  output logic [AW-1:0] c_ea,
  output logic          c_acc,
  output logic          c_wb_en,
  output logic [AW-1:0] c_wb_val,
  output logic          c_indirect
);
  localparam int STEP_PAD = AW - 3;

  logic [AW-1:0] step;
  logic [AW-1:0] dec_ptr;

  assign step    = {{STEP_PAD{1'b0}}, step_bytes(size)};
  assign dec_ptr = base_val - step;

  always_comb begin
    c_ea       = '0;
    c_acc      = 1'b0;
    c_wb_en    = 1'b0;
    c_wb_val   = '0;
    c_indirect = 1'b0;
    unique case (amode_e'(mode))
      AM_IMM, AM_REG: ;
      AM_ABS:   begin c_ea = lit;                         c_acc = 1'b1; end
      AM_RIND:  begin c_ea = base_val;                    c_acc = 1'b1; end
      AM_MIND:  begin c_indirect = 1'b1;                  c_acc = 1'b1; end
      AM_IDX:   begin c_ea = base_val + disp_x;           c_acc = 1'b1; end
      AM_BIDX:  begin c_ea = base_val + index_val;        c_acc = 1'b1; end
      AM_BIDXO: begin c_ea = base_val + index_val + disp_x; c_acc = 1'b1; end
      AM_PCREL: begin c_ea = pc + disp_x;                 c_acc = 1'b1; end
      AM_PINC: begin
        c_ea     = base_val;
        c_acc    = 1'b1;
        c_wb_en  = 1'b1;
        c_wb_val = base_val + step;
      end
      AM_PDEC: begin
        c_ea     = dec_ptr;
        c_acc    = 1'b1;
        c_wb_en  = 1'b1;
        c_wb_val = dec_ptr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ind_ctl.sv
module ea_ind_ctl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          launch,
  input  logic [AW-1:0] lit,
  input  logic          ptr_valid,
  output logic          busy,
  output logic          ptr_req,
  output logic [AW-1:0] ptr_addr,
  output logic          fin
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    addr_d  = lit;
    unique case (st_q)
      S_IDLE: if (launch) begin
        st_d    = S_WAIT;
        addr_en = 1'b1;
      end
      S_WAIT: if (ptr_valid) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign busy     = (st_q == S_WAIT);
  assign ptr_req  = busy;
  assign ptr_addr = addr_q;
  assign fin      = busy && ptr_valid;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [1:0]        size,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     lit,
  input  logic              ptr_valid,
  input  logic [AW-1:0]     ptr_data,
  output logic              busy,
  output logic              ptr_req,
  output logic [AW-1:0]     ptr_addr,
  output logic              done,
  output logic [AW-1:0]     ea,
  output logic              mem_acc,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [AW-1:0] disp_x;
  logic [AW-1:0] c_ea, c_wb_val;
  logic          c_acc, c_wb_en, c_indirect;
  logic          accept, fin;

  ea_sext #(.IN_W(DISP_W), .OUT_W(AW)) u_sext (.a(disp), .y(disp_x));

  ea_comb #(.AW(AW)) u_comb (
    .mode(mode), .size(size), .base_val(base_val), .index_val(index_val),
    .disp_x(disp_x), .pc(pc), .lit(lit),
    .c_ea(c_ea), .c_acc(c_acc), .c_wb_en(c_wb_en), .c_wb_val(c_wb_val),
    .c_indirect(c_indirect)
  );

  assign accept = start && !busy;

  ea_ind_ctl #(.AW(AW)) u_ind (
    .clk(clk), .rst_ni(rst_i_n), .launch(accept && c_indirect), .lit(lit),
    .ptr_valid(ptr_valid), .busy(busy), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr), .fin(fin)
  );

  // result register: next-state then storage
  logic          done_d, acc_d, wben_d, res_en;
  logic [AW-1:0] ea_d, wbv_d;

  always_comb begin
    res_en = 1'b0;
    done_d = 1'b0;
    ea_d   = c_ea;
    acc_d  = c_acc;
    wben_d = c_wb_en;
    wbv_d  = c_wb_val;
    if (fin) begin
      res_en = 1'b1;
      done_d = 1'b1;
      ea_d   = ptr_data;
      acc_d  = 1'b1;
      wben_d = 1'b0;
      wbv_d  = '0;
    end else if (accept && !c_indirect) begin
      res_en = 1'b1;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done    <= 1'b0;
      ea      <= '0;
      mem_acc <= 1'b0;
      wb_en   <= 1'b0;
      wb_val  <= '0;
    end else begin
      done <= done_d;
      if (res_en) begin
        ea      <= ea_d;
        mem_acc <= acc_d;
        wb_en   <= wben_d;
        wb_val  <= wbv_d;
      end
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    mode,
  input logic          ptr_valid,
  input logic [AW-1:0] ptr_data,
  input logic          busy,
  input logic          ptr_req,
  input logic [AW-1:0] ptr_addr,
  input logic          done,
  input logic          mem_acc,
  input logic          wb_en,
  input logic [AW-1:0] ea
);
  // R13
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode != 4'd4) |=> done);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req && !ptr_valid) |=> (ptr_req && $stable(ptr_addr)));

  // R11
  ind_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req && ptr_valid) |=> (done && !ptr_req && mem_acc && !wb_en
                                && ea == $past(ptr_data)));

  // R8
  no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode != 4'd9 && mode != 4'd10) |=> !wb_en);

  // R2
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode <= 4'd1 || mode >= 4'd11)) |=> !mem_acc);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_valid) |=> !done);

  // R10
  req_is_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req == busy);
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
  .ptr_valid(ptr_valid), .ptr_data(ptr_data), .busy(busy),
  .ptr_req(ptr_req), .ptr_addr(ptr_addr), .done(done),
  .mem_acc(mem_acc), .wb_en(wb_en), .ea(ea)
);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  localparam int AW = 32;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] size = '0;
  logic [AW-1:0] base_val = '0, index_val = '0, pc = '0, lit = '0, ptr_data = '0;
  logic [DW-1:0] disp = '0;
  logic ptr_valid = 1'b0;
  logic busy, ptr_req, done, mem_acc, wb_en;
  logic [AW-1:0] ptr_addr, ea, wb_val;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ea_unit #(.AW(AW), .DISP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
    .base_val(base_val), .index_val(index_val), .disp(disp), .pc(pc),
    .lit(lit), .ptr_valid(ptr_valid), .ptr_data(ptr_data), .busy(busy),
    .ptr_req(ptr_req), .ptr_addr(ptr_addr), .done(done), .ea(ea),
    .mem_acc(mem_acc), .wb_en(wb_en), .wb_val(wb_val)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (mode=%0d size=%0d)", req, act, exp, mode, size);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd5, 4'd6, 4'd7: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_direct(input logic [3:0] m, input logic [1:0] s);
    logic [AW-1:0] sx, d, e_ea, e_wbv;
    logic e_acc, e_wb;
    sx = AW'($signed(disp));
    d = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    e_ea = '0; e_acc = 1'b0; e_wb = 1'b0; e_wbv = '0;
    case (m)
      4'd2: begin e_ea = lit; e_acc = 1; end
      4'd3: begin e_ea = base_val; e_acc = 1; end
      4'd5: begin e_ea = base_val + sx; e_acc = 1; end
      4'd6: begin e_ea = base_val + index_val; e_acc = 1; end
      4'd7: begin e_ea = base_val + index_val + sx; e_acc = 1; end
      4'd8: begin e_ea = pc + sx; e_acc = 1; end
      4'd9: begin e_ea = base_val; e_acc = 1; e_wb = 1; e_wbv = base_val + d; end
      4'd10: begin e_ea = base_val - d; e_acc = 1; e_wb = 1; e_wbv = base_val - d; end
      default: ;
    endcase
    mode = m; size = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R13 done", AW'(done), 1);
    check({tag_of(m), " ea"}, ea, e_ea);
    check({tag_of(m), " mem_acc"}, AW'(mem_acc), AW'(e_acc));
    check("R8 wb_en", AW'(wb_en), AW'(e_wb));
    if (e_wb) check({tag_of(m), " wb_val"}, wb_val, e_wbv);
    @(negedge clk);
    check("R13 single pulse", AW'(done), 0);
  endtask

  task automatic run_indirect(input int wait_cyc, input logic [AW-1:0] word);
    mode = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 req", AW'(ptr_req), 1);
    check("R10 busy", AW'(busy), 1);
    check("R10 addr", ptr_addr, lit);
    check("R10 no done yet", AW'(done), 0);
    for (int i = 0; i < wait_cyc; i++) begin
      if (i == 0) begin
        mode = 4'd2; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; mode = 4'd4;
      check("R12 ignored start", AW'(done), 0);
      check("R10 req held", AW'(ptr_req), 1);
      check("R10 addr held", ptr_addr, lit);
    end
    ptr_valid = 1'b1; ptr_data = word;
    @(negedge clk);
    ptr_valid = 1'b0;
    check("R11 done", AW'(done), 1);
    check("R11 ea", ea, word);
    check("R11 mem_acc", AW'(mem_acc), 1);
    check("R11 wb_en", AW'(wb_en), 0);
    check("R11 req drop", AW'(ptr_req), 0);
    @(negedge clk);
    check("R12 no late done", AW'(done), 0);
    check("R12 result kept", ea, word);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R13 watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 done", AW'(done), 0);
    check("R1 busy", AW'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done", AW'(done), 0);
    check("R1 req", AW'(ptr_req), 0);
    check("R1 mem_acc", AW'(mem_acc), 0);
    check("R1 wb_en", AW'(wb_en), 0);
    check("R1 ea", ea, 0);
    check("R1 wb_val", wb_val, 0);

    for (int v = 0; v < 5; v++) begin
      case (v)
        0: begin base_val = 1200; index_val = 4600; disp = 16'd30; pc = 32'h0000_4000; lit = 32'h0000_0800; end
        1: begin base_val = 32'hFFFF_FFF0; index_val = 32'h20; disp = 16'hFFFF; pc = 32'h10; lit = 32'hDEAD_BEE0; end
        2: begin base_val = 32'h0; index_val = 32'hFFFF_FFFF; disp = 16'h8000; pc = 32'h0; lit = 32'h1; end
        3: begin base_val = 32'h0000_0002; index_val = 32'h8000_0000; disp = 16'h7FFF; pc = 32'hFFFF_FFFE; lit = 32'h7FFF_FFFC; end
        default: begin base_val = 32'h1234_5678; index_val = 32'h0F0F_0F0F; disp = 16'hFF00; pc = 32'h8000_0000; lit = 32'hA5A5_A5A4; end
      endcase
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < 4; s++) begin
          if (m == 4) run_indirect(s, lit ^ 32'h5555_0000 ^ AW'(s));
          else        run_direct(4'(m), 2'(s));
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule